// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Access

This block is an SPI master that a processor drives one byte at a time through two 32-bit registers: a control/status word and a data word, chosen by a single select input. A write to the control word sets the levels of three chip-select pins, an internal loopback switch and a five-bit clock divider. If that write also carries the start bit, the block sends the low byte of the data word on MOSI and shifts a byte in from MISO. When the exchange finishes, the received byte replaces the data word.

Software polls the busy bit of the control word to learn when the exchange is over, then reads the data word. The serial clock idles low. MOSI changes on falling SCK edges, MISO is sampled on rising edges, and the most significant bit goes first. The divider value in use is captured when each exchange starts, so rewriting the control word during an exchange changes the pins and the stored fields but not the exchange in flight.

Top module: `spiByteMaster`

## Requirements
- R1: After reset all three chip-select pins are high, loopback is off, the divider is 0, busy is 0, SCK is low, and the control word reads 0x0000_0015.
- R2: A control write with bit 1 set while idle makes busy read 1 from the next cycle, for exactly 16·(D+1) cycles, where D is control bits 31:27 of that same write.
- R3: Chip-select pin n (n = 0, 1, 2) equals control bit 2n from the cycle after each control write, without inversion, and this includes writes made while busy.
- R4: During an exchange SCK is low for the first D+1 cycles and then alternates every D+1 cycles, giving eight high pulses. Busy clears in the same cycle that SCK returns low after the eighth pulse.
- R5: SCK is low whenever busy is 0.
- R6: MOSI carries transmit bit 7−k during the k-th SCK period (k = 0..7, MSB first), and it changes only when SCK falls.
- R7: With loopback off, MISO is sampled on each rising SCK edge. After busy clears, the data word reads the received byte in bits 7:0 and zero in bits 31:8.
- R8: With control bit 3 set, the received byte equals the transmitted byte, and MOSI still toggles on the pin.
- R9: A control write with bit 1 set while busy does not start a second exchange. It does store the new chip-select, loopback and divider fields, and the current exchange keeps its captured divider.
- R10: The control word reads bit 0 = CS0, bit 1 = busy, bit 2 = CS1, bit 3 = loopback, bit 4 = CS2, bits 31:27 = divider, and all other bits 0. Between exchanges the data word reads the last full 32-bit value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the control word (offset 0x0), 1 selects the data word (offset 0x4) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the selected register, combinational |
| csOut | output | 3 | Chip-select pins |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong half-period count or bit count shows on the SCK pin and on the busy bit within one half-period of the error. A bad shift register shows on MOSI within one bit period. These faults are therefore caught on the cycle they happen, by comparing against a reference model every clock. Sampling on the wrong edge, a broken loopback path or a failed completion store shows only at the data word. That happens once busy clears, which for the slowest divider is 512 cycles after the start.

// File: rtl/spiPkg.sv
package spiPkg;
  // Strobes from the timing control to the shift datapath
  typedef struct packed {
    logic load;    // capture the transmit byte, exchange begins
    logic sample;  // rising SCK: take in one bit
    logic shift;   // falling SCK: present the next bit
    logic finish;  // last falling SCK: store the received byte
  } xferStrobe_t;
endpackage

// File: rtl/spiCtrl.sv
module spiCtrl
  import spiPkg::*;
#(
  parameter int DIV_W  = 5,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [DIV_W-1:0] divIn,
  output logic             busy,
  output logic             sck,
  output xferStrobe_t      strobe
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic [DIV_W-1:0] halfCnt;
  logic [DIV_W-1:0] divHold;
  logic [BIT_W-1:0] bitCnt;
  logic             tick;

  assign tick = busy && (halfCnt == divHold);

  always_comb begin
    strobe.load   = !busy && startReq;
    strobe.sample = tick && !sck;
    strobe.shift  = tick && sck && (bitCnt != LAST_BIT);
    strobe.finish = tick && sck && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      halfCnt <= '0;
      divHold <= '0;
      bitCnt  <= '0;
    end else if (!busy) begin
      if (startReq) begin
        busy    <= 1'b1;
        sck     <= 1'b0;
        halfCnt <= '0;
        bitCnt  <= '0;
        divHold <= divIn;
      end
    end else if (tick) begin
      halfCnt <= '0;
      sck     <= !sck;
      if (sck) begin
        if (bitCnt == LAST_BIT) busy <= 1'b0;
        else bitCnt <= bitCnt + 1'b1;
      end
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end
endmodule

// File: rtl/spiData.sv
module spiData
  import spiPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobe_t       strobe,
  input  logic              loopEn,
  input  logic              miso,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataIn,
  output logic              mosi,
  output logic [DATA_W-1:0] dataOut
);
  localparam int PAD_W = DATA_W - BYTE_W;

  logic [BYTE_W-1:0] shiftReg;
  logic              sampleBit;
  logic [DATA_W-1:0] dataReg;

  assign mosi    = shiftReg[BYTE_W-1];
  assign dataOut = dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      sampleBit <= 1'b0;
      dataReg   <= '0;
    end else begin
      if (strobe.load) shiftReg <= dataReg[BYTE_W-1:0];
      if (strobe.sample) sampleBit <= loopEn ? shiftReg[BYTE_W-1] : miso;
      if (strobe.shift || strobe.finish)
        shiftReg <= {shiftReg[BYTE_W-2:0], sampleBit};
      if (strobe.finish)
        dataReg <= {{PAD_W{1'b0}}, shiftReg[BYTE_W-2:0], sampleBit};
      else if (dataWr)
        dataReg <= dataIn;
    end
  end
endmodule

// File: rtl/spiByteMaster.sv
module spiByteMaster
  import spiPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 5,
  parameter int CS_N   = 3,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CS_N-1:0]   csOut,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam int BUSY_BIT = 1;
  localparam int LOOP_BIT = 3;

  logic             wrCtrl;
  logic             wrDataReg;
  logic             startReq;
  logic             busy;
  logic [CS_N-1:0]  csReg;
  logic             loopReg;
  logic [DIV_W-1:0] divReg;
  logic [DATA_W-1:0] dataOut;
  logic [DATA_W-1:0] ctrlView;
  xferStrobe_t      strobe;

  assign wrCtrl    = wrEn && !regSel;
  assign wrDataReg = wrEn && regSel;
  assign startReq  = wrCtrl && wrData[BUSY_BIT];
  assign csOut     = csReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csReg   <= '1;
      loopReg <= 1'b0;
      divReg  <= '0;
    end else if (wrCtrl) begin
      for (int n = 0; n < CS_N; n++) csReg[n] <= wrData[2*n];
      loopReg <= wrData[LOOP_BIT];
      divReg  <= wrData[DATA_W-1 -: DIV_W];
    end
  end

  always_comb begin
    ctrlView = '0;
    for (int n = 0; n < CS_N; n++) ctrlView[2*n] = csReg[n];
    ctrlView[BUSY_BIT] = busy;
    ctrlView[LOOP_BIT] = loopReg;
    ctrlView[DATA_W-1 -: DIV_W] = divReg;
  end

  assign rdData = regSel ? dataOut : ctrlView;

  spiCtrl #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .divIn(wrData[DATA_W-1 -: DIV_W]),
    .busy(busy), .sck(sck), .strobe(strobe)
  );

  spiData #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loopEn(loopReg),
    .miso(miso), .dataWr(wrDataReg), .dataIn(wrData),
    .mosi(mosi), .dataOut(dataOut)
  );
endmodule

// File: rtl/spiByteMasterChk.sv
module spiByteMasterChk (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic regSel,
  input logic startBit,
  input logic busy,
  input logic sck,
  input logic mosi
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !regSel && startBit && !busy) |=> busy); // R2

  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sck); // R5

  AST_DONE_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (!sck && $past(sck))); // R4

  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$fell(sck)) |-> $stable(mosi)); // R6
endmodule

bind spiByteMaster spiByteMasterChk uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel),
  .startBit(wrData[1]), .busy(busy), .sck(sck), .mosi(mosi)
);

// File: tb/sim_spiByteMaster.sv
`timescale 1ns/1ps
module sim_spiByteMaster;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [2:0]  csOut;
  logic        sck, mosi;
  logic        miso = 1'b0;

  always #5 clk = ~clk;

  spiByteMaster u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .rdData(rdData), .csOut(csOut), .sck(sck), .mosi(mosi), .miso(miso)
  );

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  bit [2:0]  mCs = 3'b111;
  bit        mLoop = 0;
  bit [4:0]  mDiv = 0;
  bit        mBusy = 0;
  bit [31:0] mData = 0;
  int        mE = 0;
  int        mH = 1;
  bit [7:0]  mTx = 0;
  bit [7:0]  mRx = 0;
  bit        wasBusy;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mCs = 3'b111; mLoop = 0; mDiv = 0; mBusy = 0; mData = 0; mE = 0;
    end else begin
      wasBusy = mBusy;
      if (mBusy) begin
        mE++;
        if (mE == 16*mH) begin
          mBusy = 0;
          mData = {24'h0, (mLoop ? mTx : mRx)};
        end
      end
      if (wrEn && !regSel) begin
        mCs = {wrData[4], wrData[2], wrData[0]};
        mLoop = wrData[3];
        mDiv = wrData[31:27];
        if (wrData[1] && !wasBusy) begin
          mBusy = 1; mE = 0; mH = int'(mDiv) + 1; mTx = mData[7:0];
        end
      end
      if (wrEn && regSel) mData = wrData;
    end
  end

  // remote slave: present the pattern bit for the current bit period
  always @(negedge clk) miso <= mBusy ? mRx[7 - mE/(2*mH)] : 1'b0;

  // per-cycle comparison, away from the active edge
  always @(posedge clk) begin
    #3;
    if (rstN && !done) begin
      chk("R3 csOut", {29'h0, csOut}, {29'h0, mCs});
      if (mBusy) begin
        chk("R4 sck", {31'h0, sck}, {31'h0, 1'(((mE / mH) % 2))});
        chk("R6 mosi", {31'h0, mosi}, {31'h0, mTx[7 - mE/(2*mH)]});
      end else begin
        chk("R5 sck idle", {31'h0, sck}, 32'h0);
      end
      if (!regSel) begin
        chk("R2 busy bit", {31'h0, rdData[1]}, {31'h0, mBusy});
        chk("R10 control view", rdData & ~32'h2,
            {mDiv, 22'h0, mCs[2], mLoop, mCs[1], 1'b0, mCs[0]});
      end else begin
        chk("R7 data view", rdData, mData);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000 && !done) begin
      nFail++;
      $display("FAIL watchdog R2 actual=busy expected=idle");
      finishRun();
    end
  end

  task automatic writeReg(input bit sel, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; regSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; regSel = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (mBusy);
  endtask

  task automatic readCheck(input bit sel, input string tag, input logic [31:0] exp);
    @(negedge clk);
    regSel = sel;
    @(posedge clk); #2;
    chk(tag, rdData, exp);
    @(negedge clk);
    regSel = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #2;
    chk("R1 cs reset", {29'h0, csOut}, 32'h7);
    chk("R1 control reset", rdData, 32'h0000_0015);
    chk("R1 sck reset", {31'h0, sck}, 32'h0);

    // R7: fastest divider, external MISO, CS0 low
    writeReg(1'b1, 32'hDEAD_013C);
    readCheck(1'b1, "R10 data holds word", 32'hDEAD_013C);
    mRx = 8'hA5;
    writeReg(1'b0, 32'h0000_0016);
    waitIdle();
    readCheck(1'b1, "R7 received byte", 32'h0000_00A5);

    // R8: loopback, divider 2, CS1 low
    writeReg(1'b1, 32'h0000_0096);
    mRx = 8'hFF;
    writeReg(1'b0, (32'd2 << 27) | 32'h0000_001B);
    waitIdle();
    readCheck(1'b1, "R8 loopback byte", 32'h0000_0096);

    // R9: start again while busy is ignored, fields still stored
    writeReg(1'b1, 32'h0000_005A);
    mRx = 8'h3C;
    writeReg(1'b0, (32'd1 << 27) | 32'h0000_0013);
    repeat (5) @(negedge clk);
    writeReg(1'b0, (32'd7 << 27) | 32'h0000_0007);
    waitIdle();
    readCheck(1'b0, "R9 fields after ignored start", (32'd7 << 27) | 32'h0000_0005);
    readCheck(1'b1, "R9 byte of first exchange", 32'h0000_003C);

    // R4: slowest divider
    writeReg(1'b1, 32'h0000_00C3);
    mRx = 8'h81;
    writeReg(1'b0, 32'hF800_0012);
    waitIdle();
    readCheck(1'b1, "R7 slow exchange", 32'h0000_0081);

    // R2: back-to-back exchanges with no gap
    writeReg(1'b1, 32'h0000_0001);
    mRx = 8'h7E;
    writeReg(1'b0, 32'h0000_0016);
    waitIdle();
    writeReg(1'b0, 32'h0000_0016);
    waitIdle();
    readCheck(1'b1, "R7 second back-to-back", 32'h0000_007E);

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule